// File: doc/BRIEF.md
# Manchester Response Frame Transmitter

This block drives the load-modulation switch of a low-frequency passive transponder when the tag answers a reader. The caller hands over a frame of up to 160 bits, packed as bytes, together with a bit count. The caller also gives the number of carrier periods that have already passed since the end of the reader's last pulse. The block waits out the rest of the fixed response turnaround. It then sends a short start-of-frame preamble and the payload bits, each Manchester coded. At the end it releases the modulator and pulses a done flag.

All timing is measured in carrier periods. A single-cycle strobe marks each carrier period, and no counter moves without it. One bit lasts 32 carrier periods, made of two halves of 16. The turnaround is 200 periods measured from the falling edge of the last reader pulse. A caller that only notices the rising edge after the reader gap passes the gap length as the elapsed count. Decoding of reader commands and the choice of reply belong to other blocks.

Top module: `manch_resp_tx`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `load_mod` is 0 (unloaded) and `done` is 0. Asserting `rst_n` during a transmission unloads the modulator at once.
- R2: After an accepted `start`, `load_mod` stays 0 for W carrier periods, where W = 200 − `elapsed`, or W = 0 when `elapsed` ≥ 200. Modulation begins in the carrier period that follows.
- R3: Every non-empty frame begins with five preamble bits of value one, sent before the first payload bit.
- R4: Each bit occupies 32 carrier periods, split into two halves of 16. A one is unloaded (`load_mod` = 0) in the first half and loaded (`load_mod` = 1) in the second. A zero is loaded first and unloaded second.
- R5: Byte k of the frame sits in `frame[8k+7:8k]`. Bytes go out in rising k order, and each byte goes out from bit 7 down to bit 0.
- R6: Exactly `bit_len` payload bits are sent. A `bit_len` above 160 is treated as 160.
- R7: Once the second half of the final bit ends, `load_mod` returns to 0. In the clock right after the tick that closes that half, `done` is high for exactly one cycle.
- R8: A `start` with `bit_len` = 0 produces no modulation, and `done` rises in the clock right after `start`.
- R9: A `start` that arrives while a frame is waiting or being sent is ignored. The frame in progress is not altered and no extra `done` is produced.
- R10: `load_mod` changes only in the clock after a `carrier_tick`, except at the single step into the first preamble bit. While no tick arrives, the output and the progress of the frame stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| carrier_tick | input | 1 | One-cycle strobe, once per carrier period |
| start | input | 1 | Request to send the presented frame; taken only when idle |
| elapsed | input | 8 | Carrier periods already past since the last reader pulse fell |
| frame | input | 160 | Frame bytes, byte k at bits 8k+7..8k |
| bit_len | input | 8 | Number of payload bits to send |
| load_mod | output | 1 | Modulator control, 1 = loaded |
| done | output | 1 | One-cycle pulse when the frame is finished |

## Verification
The level of carrier period k (counted from 1 after `start`) is registered in the clock after tick k−1. With no wait, it is registered two clocks after `start`. The bench therefore reads `load_mod` three clocks after every tick, just before raising the next one, and compares it with the level computed from W, the preamble and the frame bytes. `done` is due in the clock right after the tick that closes the last half. The bench notes which tick was the last one raised when `done` is seen and expects it to equal W + 32·(5 + length). For an empty frame, `done` is sampled at the first falling edge after `start`.

// File: rtl/manch_resp_pkg.sv
package manch_resp_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // Manchester level for one half of a bit: a one is unloaded then loaded.
  function automatic logic manch_level(input logic bit_val, input logic second_half);
    return second_half ? bit_val : ~bit_val;
  endfunction

endpackage

// File: rtl/manch_rst_sync.sv
module manch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/manch_wait_cnt.sv
module manch_wait_cnt #(
  parameter int TURNAROUND = 200,
  parameter int ELAPSED_W  = 8,
  parameter int CNT_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [ELAPSED_W-1:0] elapsed,
  output logic                 expired
);

  localparam int EXT_W = ((CNT_W > ELAPSED_W) ? CNT_W : ELAPSED_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, reload;
  logic [EXT_W-1:0] el_ext, turn_ext, diff;
  logic             cnt_en;

  always_comb begin
    el_ext   = EXT_W'(elapsed);
    turn_ext = EXT_W'(TURNAROUND);
    diff     = turn_ext - el_ext;
    reload   = (el_ext >= turn_ext) ? '0 : CNT_W'(diff);
  end

  always_comb begin
    cnt_en  = load | (tick & (cnt_q != '0));
    cnt_nxt = load ? reload : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/manch_half_timer.sv
module manch_half_timer #(
  parameter int HALF_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic run,
  output logic half_end
);

  localparam int HALF_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

  logic [HALF_W-1:0] cnt_q, cnt_nxt;
  logic              cnt_en, at_last;

  always_comb begin
    at_last  = (cnt_q == HALF_W'(HALF_TICKS - 1));
    cnt_en   = clear | (run & tick);
    cnt_nxt  = (clear | at_last) ? '0 : (cnt_q + 1'b1);
    half_end = run & tick & at_last & ~clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/manch_bit_sel.sv
module manch_bit_sel #(
  parameter int FRAME_BITS = 160,
  parameter int IDX_W      = 8,
  parameter int SOF_BITS   = 5,
  parameter bit SOF_LEVEL  = 1'b1
) (
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [IDX_W-1:0]      idx,
  output logic                  bit_val
);

  logic [IDX_W-1:0] pay_idx;
  logic [IDX_W-1:0] flat_idx;
  logic             pay_bit;

  always_comb begin
    pay_idx  = idx - IDX_W'(SOF_BITS);
    // MSB of each byte first: flip the bit-within-byte position
    flat_idx = {pay_idx[IDX_W-1:3], ~pay_idx[2:0]};
    pay_bit  = (flat_idx < IDX_W'(FRAME_BITS)) ? frame[flat_idx] : 1'b0;
  end

  generate
    if (SOF_BITS > 0) begin : g_with_sof
      assign bit_val = (idx < IDX_W'(SOF_BITS)) ? SOF_LEVEL : pay_bit;
    end else begin : g_no_sof
      assign bit_val = pay_bit;
    end
  endgenerate

endmodule

// File: rtl/manch_resp_tx.sv
module manch_resp_tx
  import manch_resp_pkg::*;
#(
  parameter int FRAME_BYTES = 20,
  parameter int HALF_TICKS  = 16,
  parameter int SOF_BITS    = 5,
  parameter bit SOF_LEVEL   = 1'b1,
  parameter int TURNAROUND  = 200,
  parameter int ELAPSED_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       carrier_tick,
  input  logic                       start,
  input  logic [ELAPSED_W-1:0]       elapsed,
  input  logic [FRAME_BYTES*8-1:0]   frame,
  input  logic [$clog2(FRAME_BYTES*8+1)-1:0] bit_len,
  output logic                       load_mod,
  output logic                       done
);

  localparam int FRAME_BITS = FRAME_BYTES * 8;
  localparam int LEN_W      = $clog2(FRAME_BITS + 1);
  localparam int TOTAL_W    = $clog2(FRAME_BITS + SOF_BITS + 1);
  localparam int WAIT_W     = $clog2(TURNAROUND + 1);

  logic rst_sync_n;

  tx_state_e             st_q, st_nxt;
  logic [TOTAL_W-1:0]    idx_q, idx_nxt;
  logic [TOTAL_W-1:0]    last_q, last_nxt;
  logic                  phase_q, phase_nxt;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  mod_q, mod_nxt;
  logic                  done_q, done_nxt;

  logic [LEN_W-1:0]      len_clamped;
  logic                  wait_load, wait_expired;
  logic                  timer_clear, half_end;
  logic                  frame_en;
  logic                  bit_nxt;

  manch_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  manch_wait_cnt #(
    .TURNAROUND (TURNAROUND),
    .ELAPSED_W  (ELAPSED_W),
    .CNT_W      (WAIT_W)
  ) i_wait_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (carrier_tick),
    .load    (wait_load),
    .elapsed (elapsed),
    .expired (wait_expired)
  );

  manch_half_timer #(
    .HALF_TICKS (HALF_TICKS)
  ) i_half_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (carrier_tick),
    .clear    (timer_clear),
    .run      (st_q == TX_SEND),
    .half_end (half_end)
  );

  manch_bit_sel #(
    .FRAME_BITS (FRAME_BITS),
    .IDX_W      (TOTAL_W),
    .SOF_BITS   (SOF_BITS),
    .SOF_LEVEL  (SOF_LEVEL)
  ) i_bit_sel (
    .frame   (frame_q),
    .idx     (idx_nxt),
    .bit_val (bit_nxt)
  );

  // length handling
  always_comb begin
    len_clamped = (bit_len > LEN_W'(FRAME_BITS)) ? LEN_W'(FRAME_BITS) : bit_len;
    last_nxt    = TOTAL_W'(len_clamped) + TOTAL_W'(SOF_BITS) - TOTAL_W'(1);
  end

  // next-state logic
  always_comb begin
    st_nxt      = st_q;
    idx_nxt     = idx_q;
    phase_nxt   = phase_q;
    done_nxt    = 1'b0;
    wait_load   = 1'b0;
    timer_clear = 1'b0;
    frame_en    = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        if (start) begin
          if (len_clamped == '0) begin
            done_nxt = 1'b1;
          end else begin
            st_nxt    = TX_WAIT;
            wait_load = 1'b1;
            frame_en  = 1'b1;
          end
        end
      end
      TX_WAIT: begin
        if (wait_expired) begin
          st_nxt      = TX_SEND;
          idx_nxt     = '0;
          phase_nxt   = 1'b0;
          timer_clear = 1'b1;
        end
      end
      TX_SEND: begin
        if (half_end) begin
          if (!phase_q) begin
            phase_nxt = 1'b1;
          end else if (idx_q == last_q) begin
            st_nxt    = TX_IDLE;
            phase_nxt = 1'b0;
            done_nxt  = 1'b1;
          end else begin
            idx_nxt   = idx_q + 1'b1;
            phase_nxt = 1'b0;
          end
        end
      end
      default: begin
        st_nxt = TX_IDLE;
      end
    endcase
    mod_nxt = (st_nxt == TX_SEND) && manch_level(bit_nxt, phase_nxt);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= TX_IDLE;
      idx_q   <= '0;
      phase_q <= 1'b0;
      mod_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      idx_q   <= idx_nxt;
      phase_q <= phase_nxt;
      mod_q   <= mod_nxt;
      done_q  <= done_nxt;
    end
  end

  // frame data registers, loaded on acceptance only
  always_ff @(posedge clk) begin
    if (frame_en) begin
      frame_q <= frame;
      last_q  <= last_nxt;
    end
  end

  assign load_mod = mod_q;
  assign done     = done_q;

endmodule

// File: rtl/manch_resp_tx_chk.sv
module manch_resp_tx_chk
  import manch_resp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       carrier_tick,
  input logic       start,
  input logic       len_zero,
  input logic       load_mod,
  input logic       done,
  input logic [1:0] st
);

  // R2: nothing is modulated during the turnaround wait
  assert_wait_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_WAIT) |-> !load_mod);

  // R7: done lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: at done the modulator is released and the block is idle
  assert_done_unloaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!load_mod && st == TX_IDLE));

  // R8: an empty frame completes in the next clock without modulation
  assert_empty_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == TX_IDLE && len_zero) |=> (done && !load_mod));

  // R10: while sending, the output moves only after a tick
  assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_SEND && $past(st) == TX_SEND && !$past(carrier_tick)) |-> $stable(load_mod));

endmodule

bind manch_resp_tx manch_resp_tx_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .carrier_tick (carrier_tick),
  .start        (start),
  .len_zero     (bit_len == '0),
  .load_mod     (load_mod),
  .done         (done),
  .st           (st_q)
);

// File: tb/test_manch_resp_tx.sv
`timescale 1ns/1ps
module test_manch_resp_tx;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         carrier_tick;
  logic         start;
  logic [7:0]   elapsed;
  logic [159:0] frame;
  logic [7:0]   bit_len;
  logic         load_mod;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int done_at  = -1;
  int cur_period = 0;

  always #10 clk = ~clk;

  manch_resp_tx i_manch_resp_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_tick (carrier_tick),
    .start        (start),
    .elapsed      (elapsed),
    .frame        (frame),
    .bit_len      (bit_len),
    .load_mod     (load_mod),
    .done         (done)
  );

  // vector: {pattern[1:0], elapsed[7:0], bit_len[7:0]}
  localparam int NV = 5;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'd0,   8'd8},
    {2'd1, 8'd8,   8'd12},
    {2'd2, 8'd250, 8'd3},
    {2'd3, 8'd200, 8'd16},
    {2'd1, 8'd199, 8'd1}
  };

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      done_at = cur_period;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int sel, input int k);
    case (sel)
      0: return 8'hA5 ^ 8'(k);
      1: return 8'(k * 7 + 1);
      2: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic one_tick();
    repeat (3) @(negedge clk);
    carrier_tick = 1'b1;
    @(negedge clk);
    carrier_tick = 1'b0;
  endtask

  task automatic run_frame(input int len, input int el, input int sel, input int restart_at);
    int eff, w, nbits, span, j, b, h, pb, act, expv;
    int bad_wait, bad_sof, bad_pay, bad_tail;
    int a_wait, a_sof, a_pay, a_tail, e_wait, e_sof, e_pay, e_tail;
    logic [7:0] byt;
    eff   = (len > 160) ? 160 : len;
    w     = (el >= 200) ? 0 : 200 - el;
    nbits = eff + 5;
    span  = w + 32 * nbits;
    bad_wait = 0; bad_sof = 0; bad_pay = 0; bad_tail = 0;
    a_wait = 0; a_sof = 0; a_pay = 0; a_tail = 0;
    e_wait = 0; e_sof = 0; e_pay = 0; e_tail = 0;
    for (int k = 0; k < 20; k++) frame[8*k +: 8] = byte_of(sel, k);
    bit_len = 8'(len);
    elapsed = 8'(el);
    done_cnt = 0;
    done_at  = -1;
    cur_period = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= span + 4; k++) begin
      if (k == restart_at) begin
        start   = 1'b1;
        bit_len = 8'd0;
        elapsed = 8'hFF;
      end
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      act = int'(load_mod);
      if (k <= w) begin
        expv = 0;
        if (act != expv && bad_wait == 0) begin bad_wait = k; a_wait = act; e_wait = expv; end
      end else if (k <= span) begin
        j = k - w - 1;
        b = j / 32;
        h = (j % 32) / 16;
        if (b < 5) begin
          pb = 1;
        end else begin
          byt = byte_of(sel, (b - 5) / 8);
          pb  = int'(byt[7 - ((b - 5) % 8)]);
        end
        expv = (h == 1) ? pb : 1 - pb;
        if (b < 5) begin
          if (act != expv && bad_sof == 0) begin bad_sof = k; a_sof = act; e_sof = expv; end
        end else begin
          if (act != expv && bad_pay == 0) begin bad_pay = k; a_pay = act; e_pay = expv; end
        end
      end else begin
        expv = 0;
        if (act != expv && bad_tail == 0) begin bad_tail = k; a_tail = act; e_tail = expv; end
      end
      cur_period   = k;
      carrier_tick = 1'b1;
      @(negedge clk);
      carrier_tick = 1'b0;
    end
    check(bad_wait == 0, "R2", $sformatf("turnaround level (len %0d elapsed %0d)", len, el), a_wait, e_wait);
    check(bad_sof == 0, "R3", "preamble level", a_sof, e_sof);
    check(bad_pay == 0, "R4 R5 R6", $sformatf("payload level at period %0d", bad_pay), a_pay, e_pay);
    check(bad_tail == 0, "R7", "level after last bit", a_tail, e_tail);
    check(done_cnt == 1, "R7 R9", "done pulse count", done_cnt, 1);
    check(done_at == span, "R7", "tick that precedes done", done_at, span);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: cycles actual 190000 expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    carrier_tick = 1'b0;
    start        = 1'b0;
    elapsed      = '0;
    frame        = '0;
    bit_len      = '0;
    repeat (4) @(negedge clk);
    check(load_mod == 1'b0, "R1", "load_mod in reset", load_mod, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(load_mod == 1'b0 && done == 1'b0, "R1", "outputs after release", {load_mod, done}, 0);

    // table of frames
    for (int i = 0; i < NV; i++) begin
      run_frame(int'(VEC[i][7:0]), int'(VEC[i][15:8]), int'(VEC[i][17:16]), 0);
    end

    // R6: full-size frame and an oversize length clamped to 160
    run_frame(160, 190, 1, 0);
    run_frame(200, 255, 0, 0);

    // R9: start during the wait and during the preamble is ignored
    run_frame(20, 100, 1, 60);
    run_frame(4, 230, 0, 50);

    // R8: empty frame
    done_cnt = 0;
    bit_len = 8'd0;
    elapsed = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8", "done one clock after empty start", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done pulse width", done, 0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 40; k++) begin
        one_tick();
        if (load_mod) seen++;
      end
      check(seen == 0, "R8", "loaded periods after empty start", seen, 0);
      check(done_cnt == 1, "R8", "done count for empty frame", done_cnt, 1);
    end

    // R10: output frozen while ticks pause
    frame   = '0;
    bit_len = 8'd8;
    elapsed = 8'd255;
    done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check(load_mod == 1'b0, "R10", "first preamble half before ticks", load_mod, 0);
    repeat (16) one_tick();
    repeat (2) @(negedge clk);
    check(load_mod == 1'b1, "R10", "second preamble half", load_mod, 1);
    repeat (100) @(negedge clk);
    check(load_mod == 1'b1, "R10", "level held with no ticks", load_mod, 1);
    check(done_cnt == 0, "R10", "no completion with no ticks", done_cnt, 0);
    repeat (16) one_tick();
    repeat (2) @(negedge clk);
    check(load_mod == 1'b0, "R10", "next preamble bit first half", load_mod, 0);
    repeat (16) one_tick();
    repeat (2) @(negedge clk);
    check(load_mod == 1'b1, "R1", "loaded before mid-frame reset", load_mod, 1);

    // R1: reset during a transmission releases the modulator at once
    #3 rst_n = 1'b0;
    #1;
    check(load_mod == 1'b0, "R1", "load_mod right after reset asserted", load_mod, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(load_mod == 1'b0 && done == 1'b0, "R1", "outputs after second release", {load_mod, done}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule